// File: doc/BRIEF.md
# Control Register Bank with Atomic Set/Clear/Toggle Aliases

This block is a small bank of 32-bit peripheral control registers on a plain memory-mapped write bus. Every register occupies four consecutive word addresses. The first word is the register itself. The other three are alias words. A write to an alias clears, sets or inverts only the bits that are 1 in the written data. Software can therefore change single bits in one bus cycle, with no read-modify-write sequence that an interrupt or the hardware could break.

Peripheral logic has its own per-register set and clear lanes, which it uses to raise or drop status and interrupt flags. These lanes are merged with any bus write in the same clock. Where hardware touches a bit, hardware wins, so a flag raised in the same cycle that software clears it is kept. A read at any of a register's four words returns the register contents combinationally. The whole register array is also driven out to the peripheral.

Top module: `alias_reg_bank`

## Requirements
- R1: While `rst_n` is low, and after it is released, every register holds the parameter `RESET_VAL` (default 0xA5A5_0000) until it is written or changed by hardware.
- R2: Byte address bits [ADDR_W-1:4] select the register and bits [3:2] select the operation. Operation 0 (offset 0x0) is a plain write that replaces all bits. The new value is visible on `reg_q` after the rising edge at which `bus_wr` is sampled high.
- R3: Operation 1 (offset 0x4) clears each bit that is 1 in `bus_wdata`, with the same result as an AND-NOT update.
- R4: Operation 2 (offset 0x8) sets each bit that is 1 in `bus_wdata`, with the same result as an OR update.
- R5: Operation 3 (offset 0xC) inverts each bit that is 1 in `bus_wdata`, with the same result as an XOR update.
- R6: Bits written as 0 to an alias keep their value. Registers not addressed by the write keep their value. With `bus_wr` low and no hardware request, no register changes.
- R7: The `hw_set` and `hw_clr` lanes (register i uses bits [32*i+31:32*i]) act on every clock edge, with or without a bus write. The result is (software result AND NOT `hw_clr`) OR `hw_set`. A hardware set therefore wins over both a software clear and a hardware clear.
- R8: `bus_rdata` returns the addressed register's contents at all four of its offsets. Address bits [1:0] are ignored on both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address: register index, operation, ignored byte bits |
| bus_wdata | input | DATA_W | Write data, or bit mask for an alias |
| bus_rdata | output | DATA_W | Contents of the addressed register |
| hw_set | input | NUM_REGS*DATA_W | Hardware set lanes, one word per register |
| hw_clr | input | NUM_REGS*DATA_W | Hardware clear lanes, one word per register |
| reg_q | output | NUM_REGS*DATA_W | All register contents to the peripheral |

## Verification
A fixed vector walk on one register applies each operation with sparse masks, full masks and an all-zero mask. This separates the set, clear and invert paths and shows that unselected bits are kept. Several vectors pair a software write with hardware lanes that overlap it. These tell apart the merge priorities: hardware set against software clear, hardware clear against software set, and hardware set against hardware clear. A long random mix of primary writes, alias writes and hardware updates across all registers is compared with a reference model. It exposes any cross-register decode error or dropped bit.

// File: rtl/alias_reg_pkg.sv
package alias_reg_pkg;
  // operation field carried in byte-address bits [3:2]
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_CLR   = 2'd1,
    OP_SET   = 2'd2,
    OP_INV   = 2'd3
  } alias_op_e;

  localparam int OP_LSB   = 2;
  localparam int WORD_LSB = 4;  // first register-index bit
endpackage

// File: rtl/alias_decode.sv
module alias_decode
  import alias_reg_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2,
  parameter int ADDR_W   = 6
) (
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  output logic [NUM_REGS-1:0] addr_hit,
  output logic [NUM_REGS-1:0] wr_sel,
  output alias_op_e           op
);

  logic [IDX_W-1:0] idx;
  logic             unused_byte_bits;

  assign idx              = bus_addr[ADDR_W-1:WORD_LSB];
  assign op               = alias_op_e'(bus_addr[OP_LSB+1:OP_LSB]);
  assign unused_byte_bits = ^bus_addr[OP_LSB-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign addr_hit[i] = (idx == IDX_W'(i));
    assign wr_sel[i]   = bus_wr && addr_hit[i];
  end

endmodule

// File: rtl/alias_reg_cell.sv
module alias_reg_cell
  import alias_reg_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  alias_op_e         op,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] hw_set,
  input  logic [DATA_W-1:0] hw_clr,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] sw_next;
  logic [DATA_W-1:0] merged;

  // software stage: bitwise alias operations on the current value
  always_comb begin
    sw_next = q;
    if (wr_sel) begin
      unique case (op)
        OP_WRITE: sw_next = wdata;
        OP_CLR:   sw_next = q & ~wdata;
        OP_SET:   sw_next = q | wdata;
        OP_INV:   sw_next = q ^ wdata;
        default:  sw_next = q;
      endcase
    end
  end

  // hardware stage: clear then set, so a hardware set always survives
  assign merged = (sw_next & ~hw_clr) | hw_set;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RESET_VAL;
    else        q <= merged;
  end

  AST_WRITE_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && op == OP_WRITE && hw_set == '0 && hw_clr == '0) |=> (q == $past(wdata))); // R2
  AST_CLR_BITS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && op == OP_CLR) |=> ((q & $past(wdata & ~hw_set)) == '0)); // R3
  AST_SET_BITS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && op == OP_SET) |=> ((q & $past(wdata & ~hw_clr)) == $past(wdata & ~hw_clr))); // R4
  AST_INV_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && op == OP_INV && hw_set == '0 && hw_clr == '0) |=> (q == ($past(q) ^ $past(wdata)))); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_sel && hw_set == '0 && hw_clr == '0) |=> $stable(q)); // R6
  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((q & $past(hw_set)) == $past(hw_set))); // R7

endmodule

// File: rtl/alias_reg_bank.sv
module alias_reg_bank
  import alias_reg_pkg::*;
#(
  parameter int                NUM_REGS  = 4,
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] RESET_VAL = 32'hA5A5_0000,
  localparam int               IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int               ADDR_W    = IDX_W + WORD_LSB
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  input  logic [NUM_REGS*DATA_W-1:0]   hw_set,
  input  logic [NUM_REGS*DATA_W-1:0]   hw_clr,
  output logic [NUM_REGS*DATA_W-1:0]   reg_q
);

  logic [NUM_REGS-1:0] addr_hit;
  logic [NUM_REGS-1:0] wr_sel;
  alias_op_e           op;
  logic [DATA_W-1:0]   q_arr [NUM_REGS];

  alias_decode #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W),
    .ADDR_W   (ADDR_W)
  ) u_decode (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .addr_hit (addr_hit),
    .wr_sel   (wr_sel),
    .op       (op)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    alias_reg_cell #(
      .DATA_W    (DATA_W),
      .RESET_VAL (RESET_VAL)
    ) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_sel (wr_sel[i]),
      .op     (op),
      .wdata  (bus_wdata),
      .hw_set (hw_set[i*DATA_W +: DATA_W]),
      .hw_clr (hw_clr[i*DATA_W +: DATA_W]),
      .q      (q_arr[i])
    );
    assign reg_q[i*DATA_W +: DATA_W] = q_arr[i];
  end

  // read port: any of the four offsets returns the primary contents
  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr_hit[i]) bus_rdata = q_arr[i];
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel)); // R6

endmodule

// File: tb/alias_reg_bank_test.sv
`timescale 1ns/1ps
module alias_reg_bank_test;

  localparam int          NR = 4;
  localparam logic [31:0] RV = 32'hA5A5_0000;
  localparam int          TR = 1;  // register used by the vector walk

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [5:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NR*32-1:0]  hw_set = '0;
  logic [NR*32-1:0]  hw_clr = '0;
  logic [NR*32-1:0]  reg_q;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  alias_reg_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_set(hw_set), .hw_clr(hw_clr), .reg_q(reg_q)
  );

  // {wr, op, wdata, hw_set, hw_clr, expected}
  localparam int NV = 13;
  localparam logic [130:0] VEC [NV] = '{
    {1'b1, 2'd0, 32'h1234_5678, 32'h0,         32'h0,         32'h1234_5678},
    {1'b1, 2'd2, 32'h0000_0081, 32'h0,         32'h0,         32'h1234_56F9},
    {1'b1, 2'd1, 32'h0000_00F0, 32'h0,         32'h0,         32'h1234_5609},
    {1'b1, 2'd3, 32'hFFFF_0000, 32'h0,         32'h0,         32'hEDCB_5609},
    {1'b1, 2'd3, 32'h0000_0000, 32'h0,         32'h0,         32'hEDCB_5609},
    {1'b1, 2'd1, 32'hF000_0000, 32'h8000_0000, 32'h0,         32'h8DCB_5609},
    {1'b1, 2'd2, 32'h0000_000F, 32'h0,         32'h0000_0001, 32'h8DCB_560E},
    {1'b1, 2'd0, 32'hFFFF_FFFF, 32'h0,         32'h0000_FF00, 32'hFFFF_00FF},
    {1'b1, 2'd3, 32'h0000_00FF, 32'h0000_0001, 32'h0,         32'hFFFF_0001},
    {1'b0, 2'd0, 32'h0,         32'h0000_1000, 32'h0000_1000, 32'hFFFF_1001},
    {1'b0, 2'd1, 32'hFFFF_FFFF, 32'h0,         32'h0,         32'hFFFF_1001},
    {1'b1, 2'd1, 32'hFFFF_FFFF, 32'h0,         32'h0,         32'h0000_0000},
    {1'b1, 2'd2, 32'h0000_0040, 32'h0,         32'h0,         32'h0000_0040}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lane(input logic [NR*32-1:0] v, input int i);
    return v[i*32 +: 32];
  endfunction

  function automatic logic [5:0] mk_addr(input int r, input int op);
    return {r[1:0], op[1:0], 2'b00};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  logic [31:0] mdl [NR];

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NR; i++) check("R1 reset value", lane(reg_q, i), RV);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NR; i++) check("R1 after release", lane(reg_q, i), RV);

    // vector walk on one register, R2..R7; reads at rotating offsets for R8
    for (int v = 0; v < NV; v++) begin
      bus_wr    = VEC[v][130];
      bus_addr  = mk_addr(TR, int'(VEC[v][129:128]));
      bus_wdata = VEC[v][127:96];
      hw_set    = '0;
      hw_clr    = '0;
      hw_set[TR*32 +: 32] = VEC[v][95:64];
      hw_clr[TR*32 +: 32] = VEC[v][63:32];
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; hw_set = '0; hw_clr = '0;
      check($sformatf("R2-R7 vector %0d", v), lane(reg_q, TR), VEC[v][31:0]);
      for (int i = 0; i < NR; i++)
        if (i != TR) check("R6 untouched register", lane(reg_q, i), RV);
      bus_addr = mk_addr(TR, v % 4);
      #1;
      check("R8 read at offset", bus_rdata, VEC[v][31:0]);
    end

    // R8: ignored byte bits on write and read
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'b10_00_11; bus_wdata = 32'hCAFE_F00D;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    check("R8 byte bits ignored on write", lane(reg_q, 2), 32'hCAFE_F00D);
    for (int o = 0; o < 4; o++) begin
      bus_addr = {2'd2, o[1:0], 2'b10};
      #1;
      check("R8 read any offset", bus_rdata, 32'hCAFE_F00D);
    end

    // random mix against reference model, R2..R7
    for (int i = 0; i < NR; i++) mdl[i] = lane(reg_q, i);
    for (int c = 0; c < 400; c++) begin
      bus_wr    = $urandom_range(0, 3) != 0;
      bus_addr  = 6'($urandom);
      bus_wdata = $urandom;
      for (int i = 0; i < NR; i++) begin
        hw_set[i*32 +: 32] = (c % 3 == 0) ? ($urandom & $urandom & $urandom) : 32'h0;
        hw_clr[i*32 +: 32] = (c % 5 == 0) ? ($urandom & $urandom) : 32'h0;
      end
      @(posedge clk);
      for (int i = 0; i < NR; i++) begin
        logic [31:0] s;
        s = mdl[i];
        if (bus_wr && int'(bus_addr[5:4]) == i) begin
          case (bus_addr[3:2])
            2'd0: s = bus_wdata;
            2'd1: s = s & ~bus_wdata;
            2'd2: s = s | bus_wdata;
            default: s = s ^ bus_wdata;
          endcase
        end
        mdl[i] = (s & ~lane(hw_clr, i)) | lane(hw_set, i);
      end
      @(negedge clk);
      if (c % 40 == 39)
        for (int i = 0; i < NR; i++) check("R7 random model", lane(reg_q, i), mdl[i]);
      else
        for (int i = 0; i < NR; i++)
          if (lane(reg_q, i) !== mdl[i]) check("R6 random model", lane(reg_q, i), mdl[i]);
    end
    bus_wr = 1'b0; hw_set = '0; hw_clr = '0;

    // R1: reset mid-run restores every register
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NR; i++) check("R1 reset mid-run", lane(reg_q, i), RV);

    finish_run();
  end

endmodule